// File: doc/BRIEF.md
# Address-Decoded NAND Flash Glue

This block connects one chip-select window of a processor's external bus to two byte-wide NAND flash sockets and a small register area. Everything the flash needs is derived from the address of each bus access: a three-bit field near the top of the address picks slot A, slot B or the register area. Two low address bits become the command-latch and address-latch strobes. The bus read and write strobes are passed through to the chosen slot. Software drives a NAND command by writing to an address with the command bit set, an address byte by setting the address bit, and data with both bits clear.

The register area holds a 16-bit status word. Its bit 0 shows whether the flash in the most recently accessed slot is ready. The ready/busy inputs are synchronised by two flops before they are used. Every output is registered, so each output reflects the bus inputs sampled at the previous clock edge.

Top module: `nand_glue_decoder`

## Requirements
- R1: After reset, all chip enables, CLE, ALE, WE, RE, the write-data output and the read data are zero.
- R2: With `bus_sel` high, target field `bus_addr[24:22]` = 3'b010 raises `flash_ce[0]` (slot A) and 3'b011 raises `flash_ce[1]` (slot B). At most one chip enable is ever high.
- R3: With `bus_sel` low, no chip enable, CLE, ALE, WE or RE is raised, whatever the address and strobes.
- R4: On a slot access, `flash_cle` equals `bus_addr[5]` and `flash_ale` equals `bus_addr[4]`. With both bits clear the access is a plain data transfer.
- R5: `flash_we` and `flash_re` copy `bus_wr` and `bus_rd` only during a slot access. `flash_wdata` carries `bus_wdata`.
- R6: An access to the register area (target field 3'b100) raises no chip enable, CLE, ALE, WE or RE, even when address bits 5 and 4 are set.
- R7: A read at register offset `bus_addr[7:0]` = 8'h02 returns the ready bit of the last accessed slot in bit 0, with bits 15:1 zero. The last accessed slot is slot A after reset.
- R8: Reads from any other register offset, and from unrecognised target codes, return zero. Unrecognised codes raise no chip enable.
- R9: Ready/busy inputs pass through two synchronising flops. After a change in `flash_rdy`, the first two status reads issued back to back show the old value and the third shows the new one.
- R10: A read from a slot returns `flash_rdata` zero-extended into `bus_rdata`.
- R11: Every output reflects the inputs sampled at the previous clock edge and returns to idle one cycle after the access ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus chip-select window active |
| bus_addr | input | 25 | Bus byte address |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_wdata | input | 8 | Bus write data byte |
| bus_rdata | output | 16 | Registered read data |
| flash_rdata | input | 8 | Shared flash read data byte |
| flash_rdy | input | 2 | Per-slot ready (1) / busy (0), asynchronous |
| flash_ce | output | 2 | Per-slot chip enable, active high |
| flash_cle | output | 1 | Command latch enable |
| flash_ale | output | 1 | Address latch enable |
| flash_we | output | 1 | Flash write pulse |
| flash_re | output | 1 | Flash read pulse |
| flash_wdata | output | 8 | Write data byte to flash |

## Verification
The hardest case to reach from the ports is the status bit tracking the right slot while its ready line moves through the synchroniser. The stimulus touches slot B and then slot A with different ready levels, reading status after each. It then toggles slot A's ready line in the same cycle as the first of three back-to-back status reads. This shows the exact read on which the new level appears, and shows that the other slot's level never leaks into the status bit.

// File: rtl/nand_glue_pkg.sv
package nand_glue_pkg;
  typedef struct packed {
    logic cle;
    logic ale;
    logic we;
    logic re;
  } flash_strobe_t;

  localparam int unsigned NG_SEL_W = 3;
endpackage

// File: rtl/ngd_addr_decode.sv
module ngd_addr_decode #(
  parameter int unsigned ADDR_W     = 25,
  parameter int unsigned SEL_LSB    = 22,
  parameter int unsigned SEL_W      = nand_glue_pkg::NG_SEL_W,
  parameter int unsigned NUM_SLOTS  = 2,
  parameter int unsigned SLOT_BASE  = 2,
  parameter int unsigned REGS_CODE  = 4
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_SLOTS-1:0] slot_hit,
  output logic                 reg_hit
);
  logic [SEL_W-1:0] tgt_field;
  assign tgt_field = addr[SEL_LSB +: SEL_W];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    localparam logic [SEL_W-1:0] CODE = SEL_W'(SLOT_BASE + g);
    assign slot_hit[g] = (tgt_field == CODE);
  end

  assign reg_hit = (tgt_field == SEL_W'(REGS_CODE));
endmodule

// File: rtl/ngd_rdy_sync.sv
module ngd_rdy_sync #(
  parameter int unsigned NUM_SLOTS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SLOTS-1:0] rdy_async,
  output logic [NUM_SLOTS-1:0] rdy_sync
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_sync
    logic meta_q, sync_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= rdy_async[g];
        sync_q <= meta_q;
      end
    end
    assign rdy_sync[g] = sync_q;
  end
endmodule

// File: rtl/ngd_status.sv
module ngd_status #(
  parameter int unsigned NUM_SLOTS = 2,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned RD_W      = 16,
  parameter int unsigned OFS_W     = 8,
  parameter int unsigned STAT_OFS  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_sel,
  input  logic                 bus_rd,
  input  logic [NUM_SLOTS-1:0] slot_hit,
  input  logic                 reg_hit,
  input  logic [OFS_W-1:0]     reg_ofs,
  input  logic [NUM_SLOTS-1:0] rdy_sync,
  input  logic [DATA_W-1:0]    flash_rdata,
  output logic [RD_W-1:0]      rdata_next
);
  localparam int unsigned IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic [IDX_W-1:0] last_idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_idx_q <= '0;
    end else if (bus_sel) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (slot_hit[i]) last_idx_q <= IDX_W'(i);
      end
    end
  end

  always_comb begin
    rdata_next = '0;
    if (bus_sel && bus_rd) begin
      if (|slot_hit) begin
        rdata_next = {{(RD_W-DATA_W){1'b0}}, flash_rdata};
      end else if (reg_hit && reg_ofs == OFS_W'(STAT_OFS)) begin
        rdata_next = {{(RD_W-1){1'b0}}, rdy_sync[last_idx_q]};
      end
    end
  end
endmodule

// File: rtl/nand_glue_decoder.sv
module nand_glue_decoder #(
  parameter int unsigned ADDR_W    = 25,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned RD_W      = 16,
  parameter int unsigned NUM_SLOTS = 2,
  parameter int unsigned SEL_LSB   = 22,
  parameter int unsigned SLOT_BASE = 2,
  parameter int unsigned REGS_CODE = 4,
  parameter int unsigned CLE_BIT   = 5,
  parameter int unsigned ALE_BIT   = 4,
  parameter int unsigned OFS_W     = 8,
  parameter int unsigned STAT_OFS  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_sel,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [RD_W-1:0]      bus_rdata,
  input  logic [DATA_W-1:0]    flash_rdata,
  input  logic [NUM_SLOTS-1:0] flash_rdy,
  output logic [NUM_SLOTS-1:0] flash_ce,
  output logic                 flash_cle,
  output logic                 flash_ale,
  output logic                 flash_we,
  output logic                 flash_re,
  output logic [DATA_W-1:0]    flash_wdata
);
  import nand_glue_pkg::*;

  logic [NUM_SLOTS-1:0] slot_hit;
  logic                 reg_hit;
  logic [NUM_SLOTS-1:0] rdy_sync;
  logic [RD_W-1:0]      rdata_next;
  logic                 slot_access;
  flash_strobe_t        strb_next, strb_q;

  ngd_addr_decode #(
    .ADDR_W(ADDR_W), .SEL_LSB(SEL_LSB), .SEL_W(NG_SEL_W),
    .NUM_SLOTS(NUM_SLOTS), .SLOT_BASE(SLOT_BASE), .REGS_CODE(REGS_CODE)
  ) u_dec (
    .addr(bus_addr), .slot_hit(slot_hit), .reg_hit(reg_hit)
  );

  ngd_rdy_sync #(.NUM_SLOTS(NUM_SLOTS)) u_sync (
    .clk(clk), .rst(rst), .rdy_async(flash_rdy), .rdy_sync(rdy_sync)
  );

  ngd_status #(
    .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .RD_W(RD_W),
    .OFS_W(OFS_W), .STAT_OFS(STAT_OFS)
  ) u_stat (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_rd(bus_rd),
    .slot_hit(slot_hit), .reg_hit(reg_hit), .reg_ofs(bus_addr[OFS_W-1:0]),
    .rdy_sync(rdy_sync), .flash_rdata(flash_rdata), .rdata_next(rdata_next)
  );

  assign slot_access   = bus_sel && (|slot_hit);
  assign strb_next.cle = slot_access && bus_addr[CLE_BIT];
  assign strb_next.ale = slot_access && bus_addr[ALE_BIT];
  assign strb_next.we  = slot_access && bus_wr;
  assign strb_next.re  = slot_access && bus_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      flash_ce    <= '0;
      strb_q      <= '0;
      flash_wdata <= '0;
      bus_rdata   <= '0;
    end else begin
      flash_ce    <= bus_sel ? slot_hit : '0;
      strb_q      <= strb_next;
      flash_wdata <= bus_wdata;
      bus_rdata   <= rdata_next;
    end
  end

  assign flash_cle = strb_q.cle;
  assign flash_ale = strb_q.ale;
  assign flash_we  = strb_q.we;
  assign flash_re  = strb_q.re;

  assert_ce_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flash_ce));
  assert_idle_when_unselected_R3: assert property (@(posedge clk) disable iff (rst)
    !bus_sel |=> (flash_ce == '0 && !flash_cle && !flash_ale && !flash_we && !flash_re));
  assert_latch_needs_ce_R4: assert property (@(posedge clk) disable iff (rst)
    (flash_cle || flash_ale) |-> (|flash_ce));
  assert_strobe_needs_ce_R5: assert property (@(posedge clk) disable iff (rst)
    (flash_we || flash_re) |-> (|flash_ce));
  assert_regs_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && reg_hit) |=> (flash_ce == '0 && !flash_cle && !flash_ale && !flash_we && !flash_re));
  assert_status_upper_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_rd && reg_hit) |=> (bus_rdata[RD_W-1:1] == '0));
  assert_unknown_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !reg_hit && !(|slot_hit)) |=> (flash_ce == '0 && bus_rdata == '0));
endmodule

// File: tb/nand_glue_decoder_tb_top.sv
module nand_glue_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic [24:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  flash_rdata = '0;
  logic [1:0]  flash_rdy = 2'b11;
  logic [1:0]  flash_ce;
  logic        flash_cle, flash_ale, flash_we, flash_re;
  logic [7:0]  flash_wdata;

  int n_checks = 0;
  int n_fail = 0;

  localparam logic [24:0] SLOT_A = 25'h0800000;
  localparam logic [24:0] SLOT_B = 25'h0C00000;
  localparam logic [24:0] REGS   = 25'h1000000;

  always #2 clk = ~clk;

  nand_glue_decoder dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .flash_rdata(flash_rdata), .flash_rdy(flash_rdy),
    .flash_ce(flash_ce), .flash_cle(flash_cle), .flash_ale(flash_ale),
    .flash_we(flash_we), .flash_re(flash_re), .flash_wdata(flash_wdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // strobes packed as {ce[1:0], cle, ale, we, re}
  function automatic logic [31:0] strobes();
    return {26'd0, flash_ce, flash_cle, flash_ale, flash_we, flash_re};
  endfunction

  // drive at negedge, clock once, return at next negedge
  task automatic cyc(input logic sel, input logic [24:0] a, input logic rd,
                     input logic wr, input logic [7:0] wd);
    bus_sel = sel; bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    cyc(1'b0, '0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic t_reset();
    check("R1 strobes", strobes(), 32'h0);
    check("R1 rdata", 32'(bus_rdata), 32'h0);
    check("R1 wdata", 32'(flash_wdata), 32'h0);
  endtask

  task automatic t_slots();
    cyc(1'b1, SLOT_A, 1'b0, 1'b1, 8'h5A);
    check("R2 R5 slot A write", strobes(), 32'b01_00_10);
    check("R5 wdata", 32'(flash_wdata), 32'h5A);
    idle();
    check("R11 back to idle", strobes(), 32'h0);
    flash_rdata = 8'hC3;
    cyc(1'b1, SLOT_B, 1'b1, 1'b0, 8'h00);
    check("R2 R5 slot B read", strobes(), 32'b10_00_01);
    check("R10 slot read data", 32'(bus_rdata), 32'h00C3);
    idle();
  endtask

  task automatic t_latches();
    cyc(1'b1, SLOT_A | 25'h20, 1'b0, 1'b1, 8'h70);
    check("R4 command latch", strobes(), 32'b01_10_10);
    cyc(1'b1, SLOT_B | 25'h10, 1'b0, 1'b1, 8'h01);
    check("R4 address latch", strobes(), 32'b10_01_10);
    cyc(1'b1, SLOT_B | 25'h30, 1'b0, 1'b0, 8'h00);
    check("R4 both latches", strobes(), 32'b10_11_00);
    cyc(1'b1, SLOT_A | 25'h0F, 1'b0, 1'b1, 8'hA5);
    check("R4 plain data", strobes(), 32'b01_00_10);
    idle();
  endtask

  task automatic t_unselected();
    cyc(1'b0, SLOT_A | 25'h30, 1'b1, 1'b1, 8'hFF);
    check("R3 no chip select", strobes(), 32'h0);
    idle();
  endtask

  task automatic t_regs();
    cyc(1'b1, REGS | 25'h30, 1'b0, 1'b1, 8'h80);
    check("R6 register write quiet", strobes(), 32'h0);
    cyc(1'b1, REGS | 25'h32, 1'b1, 1'b0, 8'h00);
    check("R6 register read quiet", strobes(), 32'h0);
    idle();
  endtask

  task automatic t_status();
    flash_rdy = 2'b01;        // slot A ready, slot B busy
    repeat (3) idle();
    cyc(1'b1, SLOT_B, 1'b0, 1'b0, 8'h00);
    cyc(1'b1, REGS | 25'h02, 1'b1, 1'b0, 8'h00);
    check("R7 status after slot B", 32'(bus_rdata), 32'h0000);
    cyc(1'b1, SLOT_A, 1'b0, 1'b0, 8'h00);
    cyc(1'b1, REGS | 25'h02, 1'b1, 1'b0, 8'h00);
    check("R7 status after slot A", 32'(bus_rdata), 32'h0001);
    idle();
  endtask

  task automatic t_others();
    cyc(1'b1, REGS | 25'h04, 1'b1, 1'b0, 8'h00);
    check("R8 other offset", 32'(bus_rdata), 32'h0);
    flash_rdata = 8'h77;
    cyc(1'b1, 25'h0000002, 1'b1, 1'b0, 8'h00);
    check("R8 code 0 data", 32'(bus_rdata), 32'h0);
    check("R8 code 0 strobes", strobes(), 32'h0);
    cyc(1'b1, 25'h1400002, 1'b1, 1'b1, 8'h00);
    check("R8 code 5 data", 32'(bus_rdata), 32'h0);
    check("R8 code 5 strobes", strobes(), 32'h0);
    idle();
  endtask

  task automatic t_sync();
    // last slot is A and A reads ready; drop it with the first read
    flash_rdy = 2'b00;
    cyc(1'b1, REGS | 25'h02, 1'b1, 1'b0, 8'h00);
    check("R9 read 1 old", 32'(bus_rdata), 32'h0001);
    cyc(1'b1, REGS | 25'h02, 1'b1, 1'b0, 8'h00);
    check("R9 read 2 old", 32'(bus_rdata), 32'h0001);
    cyc(1'b1, REGS | 25'h02, 1'b1, 1'b0, 8'h00);
    check("R9 read 3 new", 32'(bus_rdata), 32'h0000);
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    idle();
    t_slots();
    t_latches();
    t_unselected();
    t_regs();
    t_status();
    t_others();
    t_sync();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule